// File: doc/BRIEF.md
# Two-Stage Crosspoint Routing Controller

This block holds and applies the routing of a non-blocking single-bit crosspoint with 34 data inputs and 34 data outputs. Every output owns two 6-bit selection registers: a staging register that receives new routing, and an active register that steers that output's 34:1 multiplexer. Software-like control logic writes staging registers with a level strobe `load` and makes all of them active together with a second strobe `commit`. Both strobes are sampled on the system clock.

Four write modes exist. Bit 0 of `mode` picks a single-target write (0) or a mask write (1). Bit 1 of `mode` picks a user-given input (0) or the pass-through input, where output n takes input n (1). A 6-bit port code maps to a port as plain binary for codes 0 to 31. Any code with the top two bits 10 names port 32, and any code with the top two bits 11 names port 33. While `commit` is high the active routing may change, and only on the outputs whose selection changes. All other outputs keep passing data with no gap.

Top module: `xbar_route_ctrl`

## Requirements
- R1: After a clock edge with `rst` high, every output n carries input n in both the staging and the active register.
- R2: With `mode` = 2'b00, a clock edge with `load` high sets the staging register of output `port(out_sel[5:0])` to input `port(in_addr)`; `out_sel[33:6]` has no effect.
- R3: With `mode` = 2'b10 (bit 1 set, bit 0 clear), a load sets the staging register of output `port(out_sel[5:0])` to its own index; `in_addr` has no effect.
- R4: With `mode` = 2'b01, a load sets the staging register of every output n whose bit `out_sel[n]` is 1 to input `port(in_addr)` in that one edge.
- R5: With `mode` = 2'b11, a load sets every output n selected by `out_sel[n]` = 1 to input n; `in_addr` has no effect.
- R6: `port(c)` is `c` for c in 0..31, 32 for c in 32..47 (binary 10xxxx), and 33 for c in 48..63 (binary 11xxxx). This applies to `in_addr` and to the single-target output code.
- R7: Loads without `commit` never change the active routing. Several loads may precede one commit, and a later load of the same output replaces the earlier one.
- R8: The staging register of an output that a load does not target is unchanged. A mask write with `out_sel` all zero changes nothing.
- R9: A clock edge with `commit` high copies all 34 staging registers into the active registers at once. With `commit` low the active routing holds.
- R10: When `load` and `commit` are high at the same edge, the newly loaded selection is active right after that edge. This also holds when `commit` stays high across many loads.
- R11: `data_out[n]` equals `data_in[active(n)]` with no clock delay. New routing shows from the clock edge that commits it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous reset to pass-through, active high |
| load | input | 1 | Staging write strobe, level sensitive |
| commit | input | 1 | Global staging-to-active copy strobe, level sensitive |
| mode | input | 2 | Bit 0: mask write; bit 1: pass-through input |
| in_addr | input | 6 | Input port code used by the user-input modes |
| out_sel | input | 34 | Low 6 bits: output code (single modes); all bits: target mask (mask modes) |
| data_in | input | 34 | Crosspoint data inputs |
| data_out | output | 34 | Crosspoint data outputs |

## Verification
The bench sweeps all 64 output codes and many input codes, so the aliased codes for ports 32 and 33 are covered in both address roles. A decoder that treated them as binary would route to a missing port or to the wrong alias. Loads that are not followed by a commit are checked against the old routing, which exposes a design that lets staging leak into the active registers. A commit raised in the same edge as a load catches a design that copies the stale staging value. Zero-mask writes and untargeted outputs catch a decoder that writes spuriously. Routing is read back only through the data path, by driving the inputs with bit patterns of their own indices.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  parameter int XP_PORTS   = 34;
  parameter int XP_SEL_W   = 6;
  localparam int XP_BIN_PORTS = 2 ** (XP_SEL_W - 1);

  typedef logic [XP_SEL_W-1:0] sel_t;

  // Map a port code to a port index: low half binary, upper half aliases
  // onto the two extra ports selected by the second-highest bit.
  function automatic sel_t xp_decode(input sel_t code);
    if (code[XP_SEL_W-1])
      return sel_t'(XP_BIN_PORTS) + sel_t'(code[XP_SEL_W-2]);
    return code;
  endfunction
endpackage

// File: rtl/xbar_addr_decode.sv
module xbar_addr_decode
  import xbar_pkg::*;
#(
  parameter int N = XP_PORTS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                mode,
  input  sel_t                      in_addr,
  input  logic [N-1:0]              out_sel,
  output logic [N-1:0]              tgt_mask,
  output logic [N-1:0][XP_SEL_W-1:0] new_sel
);
  logic multi_mode;
  logic pass_mode;
  sel_t in_port;
  sel_t out_port;

  function automatic logic [N-1:0] pick_one(input sel_t idx);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (idx == sel_t'(i));
    return r;
  endfunction

  assign multi_mode = mode[0];
  assign pass_mode  = mode[1];
  assign in_port    = xp_decode(in_addr);
  assign out_port   = xp_decode(out_sel[XP_SEL_W-1:0]);

  always_comb tgt_mask = multi_mode ? out_sel : pick_one(out_port);

  for (genvar n = 0; n < N; n++) begin : g_sel
    assign new_sel[n] = pass_mode ? sel_t'(n) : in_port;
  end

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
    !multi_mode |-> ($countones(tgt_mask) == 1)); // R2
endmodule

// File: rtl/xbar_cfg_stage.sv
module xbar_cfg_stage
  import xbar_pkg::*;
#(
  parameter int N = XP_PORTS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic                       commit,
  input  logic [N-1:0]               tgt_mask,
  input  logic [N-1:0][XP_SEL_W-1:0] new_sel,
  output logic [N-1:0][XP_SEL_W-1:0] cfg_sel
);
  logic [N-1:0][XP_SEL_W-1:0] prog_q;
  logic [N-1:0][XP_SEL_W-1:0] prog_next;
  logic [N-1:0]               wr_evt;

  for (genvar n = 0; n < N; n++) begin : g_port
    assign wr_evt[n]    = load & tgt_mask[n];
    assign prog_next[n] = wr_evt[n] ? new_sel[n] : prog_q[n];

    always_ff @(posedge clk) begin
      if (rst) begin
        prog_q[n]  <= sel_t'(n);
        cfg_sel[n] <= sel_t'(n);
      end else begin
        prog_q[n] <= prog_next[n];
        if (commit) cfg_sel[n] <= prog_next[n];
      end
    end

    AST_UNTARGETED_HOLD: assert property (@(posedge clk) disable iff (rst)
      (load && !tgt_mask[n]) |=> $stable(prog_q[n])); // R8
    AST_ROUTE_RANGE: assert property (@(posedge clk) disable iff (rst)
      cfg_sel[n] < sel_t'(N)); // R6
  end

  AST_PROG_IDLE: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(prog_q)); // R7
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(cfg_sel)); // R9
  AST_CFG_COPY: assert property (@(posedge clk) disable iff (rst)
    commit |=> (cfg_sel == prog_q)); // R10
endmodule

// File: rtl/xbar_mux_core.sv
module xbar_mux_core
  import xbar_pkg::*;
#(
  parameter int N = XP_PORTS
) (
  input  logic [N-1:0]               data_in,
  input  logic [N-1:0][XP_SEL_W-1:0] cfg_sel,
  output logic [N-1:0]               data_out
);
  for (genvar n = 0; n < N; n++) begin : g_mux
    assign data_out[n] = (cfg_sel[n] < sel_t'(N)) ? data_in[cfg_sel[n]] : 1'b0;
  end
endmodule

// File: rtl/xbar_route_ctrl.sv
module xbar_route_ctrl
  import xbar_pkg::*;
#(
  parameter int N = XP_PORTS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                commit,
  input  logic [1:0]          mode,
  input  logic [XP_SEL_W-1:0] in_addr,
  input  logic [N-1:0]        out_sel,
  input  logic [N-1:0]        data_in,
  output logic [N-1:0]        data_out
);
  logic [N-1:0]               tgt_mask;
  logic [N-1:0][XP_SEL_W-1:0] new_sel;
  logic [N-1:0][XP_SEL_W-1:0] cfg_sel;

  xbar_addr_decode #(.N(N)) i_decode (
    .clk(clk), .rst(rst), .mode(mode), .in_addr(in_addr),
    .out_sel(out_sel), .tgt_mask(tgt_mask), .new_sel(new_sel)
  );

  xbar_cfg_stage #(.N(N)) i_stage (
    .clk(clk), .rst(rst), .load(load), .commit(commit),
    .tgt_mask(tgt_mask), .new_sel(new_sel), .cfg_sel(cfg_sel)
  );

  xbar_mux_core #(.N(N)) i_core (
    .data_in(data_in), .cfg_sel(cfg_sel), .data_out(data_out)
  );
endmodule

// File: tb/test_xbar_route_ctrl.sv
`timescale 1ns/1ps
module test_xbar_route_ctrl;
  localparam int N = 34;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic        commit = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [5:0]  in_addr = '0;
  logic [33:0] out_sel = '0;
  logic [33:0] data_in = '0;
  logic [33:0] data_out;

  int exp_prog [N];
  int exp_cfg  [N];
  int n_checks = 0;
  int n_fails  = 0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk = ~clk;

  xbar_route_ctrl i_xbar_route_ctrl (
    .clk(clk), .rst(rst), .load(load), .commit(commit), .mode(mode),
    .in_addr(in_addr), .out_sel(out_sel), .data_in(data_in), .data_out(data_out)
  );

  function automatic int bport(input int c);
    if (c >= 48) return 33;
    if (c >= 32) return 32;
    return c;
  endfunction

  function automatic logic [63:0] nxt(input logic [63:0] s);
    logic [63:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  task automatic step(input logic ld, input logic cf, input logic [1:0] md,
                      input logic [5:0] ia, input logic [33:0] os);
    @(negedge clk);
    load = ld; commit = cf; mode = md; in_addr = ia; out_sel = os;
    @(posedge clk);
    for (int n = 0; n < N; n++) begin
      logic tg;
      int   ns;
      tg = md[0] ? os[n] : (bport(int'(os[5:0])) == n);
      ns = md[1] ? n : bport(int'(ia));
      if (ld && tg) exp_prog[n] = ns;
      if (cf) exp_cfg[n] = exp_prog[n];
    end
  endtask

  task automatic check_routes(input string tag);
    int obs [N];
    @(negedge clk);
    load = 1'b0; commit = 1'b0;
    for (int n = 0; n < N; n++) obs[n] = 0;
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < N; i++) data_in[i] = ((i >> k) & 1) != 0;
      #0.1;
      for (int n = 0; n < N; n++) if (data_out[n]) obs[n] += (1 << k);
    end
    for (int n = 0; n < N; n++) begin
      n_checks++;
      if (obs[n] != exp_cfg[n]) begin
        n_fails++;
        $display("FAIL %s/R11 output %0d routes input %0d, expected %0d",
                 tag, n, obs[n], exp_cfg[n]);
      end
    end
  endtask

  task automatic scramble();
    step(1'b1, 1'b1, 2'b01, 6'd7, 34'h3_FFFF_FFFF);
  endtask

  initial begin
    #(200000 * 4);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < N; n++) begin exp_prog[n] = n; exp_cfg[n] = n; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check_routes("R1");

    // R2 / R6: every output code, user input, upper select bits as noise
    for (int c = 0; c < 64; c++) begin
      lfsr = nxt(lfsr);
      step(1'b1, 1'b0, 2'b00, 6'((c * 11 + 3) % 64), {lfsr[27:0], 6'(c)});
      if (c % 16 == 5) check_routes("R7");
      step(1'b0, 1'b1, 2'b00, 6'd0, 34'd0);
      check_routes("R2_R6");
    end

    // R3: single pass-through, in_addr as noise
    scramble();
    for (int c = 0; c < 64; c++) begin
      lfsr = nxt(lfsr);
      step(1'b1, 1'b0, 2'b10, lfsr[5:0], {lfsr[33:6], 6'(c)});
      if (c % 8 == 7) begin
        step(1'b0, 1'b1, 2'b00, 6'd0, 34'd0);
        check_routes("R3");
      end
    end

    // R4: mask writes with user input, all input codes
    for (int it = 0; it < 64; it++) begin
      lfsr = nxt(lfsr);
      step(1'b1, 1'b0, 2'b01, 6'(it), lfsr[33:0] & nxt(lfsr)[33:0]);
      if (it % 3 == 2) begin
        step(1'b0, 1'b1, 2'b00, 6'd0, 34'd0);
        check_routes("R4");
      end
    end

    // R5: mask writes with pass-through
    for (int it = 0; it < 20; it++) begin
      scramble();
      lfsr = nxt(lfsr);
      step(1'b1, 1'b0, 2'b11, lfsr[39:34], lfsr[33:0]);
      step(1'b0, 1'b1, 2'b00, 6'd0, 34'd0);
      check_routes("R5");
    end

    // R8: zero masks change nothing
    step(1'b1, 1'b1, 2'b01, 6'd50, 34'h2_AAAA_5555);
    step(1'b1, 1'b0, 2'b01, 6'd9, 34'd0);
    step(1'b1, 1'b0, 2'b11, 6'd9, 34'd0);
    step(1'b0, 1'b1, 2'b00, 6'd0, 34'd0);
    check_routes("R8");

    // R7 / R9: accumulate loads, later wins, one simultaneous commit
    step(1'b1, 1'b0, 2'b00, 6'd12, 34'd3);
    step(1'b1, 1'b0, 2'b00, 6'd40, 34'd3);
    step(1'b1, 1'b0, 2'b00, 6'd63, 34'd44);
    step(1'b1, 1'b0, 2'b01, 6'd1, 34'h0_0000_0F00);
    check_routes("R7");
    step(1'b0, 1'b1, 2'b00, 6'd0, 34'd0);
    check_routes("R9");
    step(1'b0, 1'b1, 2'b00, 6'd0, 34'd0);
    check_routes("R9");

    // R10: load together with commit, and commit held high
    step(1'b1, 1'b1, 2'b00, 6'd33, 34'd0);
    check_routes("R10");
    step(1'b1, 1'b1, 2'b01, 6'd20, 34'h1_0000_0001);
    step(1'b1, 1'b1, 2'b10, 6'd20, 34'd0);
    step(1'b1, 1'b1, 2'b00, 6'd47, 34'd31);
    check_routes("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule